// File: doc/BRIEF.md
# Two-Phase Early-Termination Block Matching Engine

This block performs integer full-search block matching. It compares one current block with every candidate position inside a square search window and reports the candidate with the lowest sum of absolute differences (SAD). The cost of each candidate is formed in two parts. A wide parallel datapath sums the absolute differences of the even-indexed rows in a single cycle. A narrow datapath then sums the odd-indexed rows one row per cycle. The narrow datapath runs only for candidates whose even-row partial is still strictly below the best full SAD found so far. Candidates that cannot win are therefore dropped after half their rows.

Software or a controller upstream presents a flattened current block, a flattened search window and a predicted motion vector, then pulses `start`. The engine copies both pixel sets into local buffers once. Every overlapping candidate reads its pixels from those buffers, so nothing is fetched again. Before the raster scan starts, the engine computes the full SAD at the predicted position. That value becomes the initial rejection threshold. The two datapaths work at the same time. The parallel datapath keeps scanning while the row-serial one completes earlier survivors through a single-entry hand-over slot.

Top module: `me_search_top`

## Requirements
- R1: After reset, `done` is 0, `best_sad` is 0, and `best_dx` and `best_dy` are 0.
- R2: A `start` pulse while idle captures `cur_blk` and `search_win`. Current pixel (r,c) sits at bits [(r*BLK+c)*PIX_W +: PIX_W]. Window pixel (y,x) sits at bits [(y*WIN+x)*PIX_W +: PIX_W], where WIN = BLK+2*RANGE. The SAD of offset (dy,dx) is the sum over all r,c of |cur(r,c) - win(r+dy+RANGE, c+dx+RANGE)|. Every offset with dy and dx in -RANGE..RANGE is considered. The scan order is raster, with dy in the outer loop and dx in the inner loop, both ascending.
- R3: The predicted vector is clamped to -RANGE..RANGE on each axis. The full SAD at the clamped position seeds the best result before the scan begins.
- R4: A scanned candidate replaces the best result only if its full SAD is strictly smaller. The reported vector is therefore the clamped prediction when its SAD equals the minimum. Otherwise it is the first minimum in scan order.
- R5: The even-row partial is compared with the best SAD as it stands in that cycle, and odd rows are summed only when the partial is strictly smaller. When the predicted position has SAD 0, `done` rises within NCAND+16 cycles of the `start` pulse, where NCAND = (2*RANGE+1)^2.
- R6: At most one survivor waits for the row-serial datapath. The scan holds its position while a survivor finds that slot occupied, and the result is unaffected.
- R7: `done` is high for exactly one cycle, after the last candidate has been resolved. The result outputs then hold until the next accepted `start`.
- R8: A `start` pulse during a search is ignored, and the search completes on the pixels captured at the accepted `start`.
- R9: `best_dx` and `best_dy` are two's-complement offsets MV_W bits wide, and `best_sad` is the unsigned SAD, SAD_W bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search (accepted only when idle) |
| cur_blk | input | BLK*BLK*PIX_W | Flattened current block |
| search_win | input | WIN*WIN*PIX_W | Flattened search window |
| pred_dx | input | MV_W | Predicted horizontal offset, signed |
| pred_dy | input | MV_W | Predicted vertical offset, signed |
| best_dx | output | MV_W | Winning horizontal offset, signed |
| best_dy | output | MV_W | Winning vertical offset, signed |
| best_sad | output | SAD_W | SAD of the winning offset |
| done | output | 1 | One-cycle pulse when the search ends |

## Verification
The bench builds the engine with its defaults: an 8x8 block of 8-bit pixels and a range of 4, which gives a 16x16 window and 81 candidates. At this size the even-row partial is often below the threshold on random data, so the single hand-over slot fills and the scan stalls. Structured windows at the same size produce ties across a whole row of candidates, exact embedded matches, clamped predictions and the largest possible SAD of 16320.

// File: rtl/mesad_pkg.sv
package mesad_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEED,
    ST_SETTLE,
    ST_SCAN,
    ST_DRAIN
  } mesad_state_e;

  // magnitude of the difference of two unsigned pixels
  function automatic logic [15:0] abs_diff(input logic [15:0] a, input logic [15:0] b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

endpackage

// File: rtl/mesad_row_sum.sv
module mesad_row_sum #(
  parameter int PIX_W = 8,
  parameter int BLK   = 8,
  parameter int WIN   = 16,
  parameter int OW    = 4,
  parameter int RW    = 3,
  parameter int SAD_W = 15
) (
  input  logic [BLK*BLK*PIX_W-1:0] cur,
  input  logic [WIN*WIN*PIX_W-1:0] win,
  input  logic [OW-1:0]            oy,
  input  logic [OW-1:0]            ox,
  input  logic [RW-1:0]            row,
  output logic [SAD_W-1:0]         sum
);
  import mesad_pkg::*;

  always_comb begin
    sum = '0;
    for (int c = 0; c < BLK; c++) begin
      sum = sum + SAD_W'(abs_diff(
              16'(cur[(int'(row)*BLK + c)*PIX_W +: PIX_W]),
              16'(win[((int'(oy) + int'(row))*WIN + int'(ox) + c)*PIX_W +: PIX_W])));
    end
  end

endmodule

// File: rtl/mesad_even_sum.sv
module mesad_even_sum #(
  parameter int PIX_W = 8,
  parameter int BLK   = 8,
  parameter int WIN   = 16,
  parameter int OW    = 4,
  parameter int SAD_W = 15
) (
  input  logic [BLK*BLK*PIX_W-1:0] cur,
  input  logic [WIN*WIN*PIX_W-1:0] win,
  input  logic [OW-1:0]            oy,
  input  logic [OW-1:0]            ox,
  output logic [SAD_W-1:0]         part
);
  localparam int HALF = BLK / 2;
  localparam int RW   = $clog2(BLK);

  logic [SAD_W-1:0] row_part [HALF];

  // one row datapath per even row, all evaluated in the same cycle
  for (genvar g = 0; g < HALF; g++) begin : g_even_row
    mesad_row_sum #(
      .PIX_W(PIX_W), .BLK(BLK), .WIN(WIN), .OW(OW), .RW(RW), .SAD_W(SAD_W)
    ) u_row (
      .cur(cur), .win(win), .oy(oy), .ox(ox),
      .row(RW'(2*g)), .sum(row_part[g])
    );
  end

  always_comb begin
    part = '0;
    for (int g = 0; g < HALF; g++) part = part + row_part[g];
  end

endmodule

// File: rtl/mesad_odd_unit.sv
module mesad_odd_unit #(
  parameter int PIX_W = 8,
  parameter int BLK   = 8,
  parameter int WIN   = 16,
  parameter int OW    = 4,
  parameter int SAD_W = 15
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [BLK*BLK*PIX_W-1:0] cur,
  input  logic [WIN*WIN*PIX_W-1:0] win,
  input  logic                     push,
  input  logic [OW-1:0]            push_oy,
  input  logic [OW-1:0]            push_ox,
  input  logic [SAD_W-1:0]         push_part,
  input  logic                     push_seed,
  output logic                     q_full,
  output logic                     idle,
  output logic                     commit,
  output logic [OW-1:0]            commit_oy,
  output logic [OW-1:0]            commit_ox,
  output logic [SAD_W-1:0]         commit_sad,
  output logic                     commit_seed
);
  localparam int HALF = BLK / 2;
  localparam int RW   = $clog2(BLK);
  localparam int KW   = (HALF > 1) ? $clog2(HALF) : 1;

  // single waiting slot
  logic             q_v;
  logic [OW-1:0]    q_oy, q_ox;
  logic [SAD_W-1:0] q_part;
  logic             q_seed;

  // candidate being finished row by row
  logic             act_v;
  logic [OW-1:0]    act_oy, act_ox;
  logic [SAD_W-1:0] act_acc;
  logic [KW-1:0]    act_k;
  logic             act_seed;

  logic [SAD_W-1:0] row_sum;
  logic [RW-1:0]    row_sel;
  logic             last_row;
  logic             load_ok;

  assign row_sel  = RW'(2*int'(act_k) + 1);
  assign last_row = act_v && (act_k == KW'(HALF-1));
  assign load_ok  = !act_v || last_row;

  mesad_row_sum #(
    .PIX_W(PIX_W), .BLK(BLK), .WIN(WIN), .OW(OW), .RW(RW), .SAD_W(SAD_W)
  ) u_row (
    .cur(cur), .win(win), .oy(act_oy), .ox(act_ox),
    .row(row_sel), .sum(row_sum)
  );

  assign q_full      = q_v;
  assign idle        = !act_v && !q_v;
  assign commit      = last_row;
  assign commit_oy   = act_oy;
  assign commit_ox   = act_ox;
  assign commit_sad  = act_acc + row_sum;
  assign commit_seed = act_seed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_v      <= 1'b0;
      q_oy     <= '0;
      q_ox     <= '0;
      q_part   <= '0;
      q_seed   <= 1'b0;
      act_v    <= 1'b0;
      act_oy   <= '0;
      act_ox   <= '0;
      act_acc  <= '0;
      act_k    <= '0;
      act_seed <= 1'b0;
    end else begin
      if (push) begin
        q_v    <= 1'b1;
        q_oy   <= push_oy;
        q_ox   <= push_ox;
        q_part <= push_part;
        q_seed <= push_seed;
      end else if (q_v && load_ok) begin
        q_v <= 1'b0;
      end

      if (q_v && load_ok) begin
        act_v    <= 1'b1;
        act_oy   <= q_oy;
        act_ox   <= q_ox;
        act_acc  <= q_part;
        act_k    <= '0;
        act_seed <= q_seed;
      end else if (last_row) begin
        act_v <= 1'b0;
      end else if (act_v) begin
        act_acc <= act_acc + row_sum;
        act_k   <= act_k + KW'(1);
      end
    end
  end

endmodule

// File: rtl/me_search_top.sv
module me_search_top #(
  parameter int PIX_W = 8,
  parameter int BLK   = 8,
  parameter int RANGE = 4,
  parameter int MV_W  = 8,
  parameter int WIN   = BLK + 2*RANGE,
  parameter int SAD_W = PIX_W + $clog2(BLK*BLK) + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [BLK*BLK*PIX_W-1:0] cur_blk,
  input  logic [WIN*WIN*PIX_W-1:0] search_win,
  input  logic signed [MV_W-1:0]   pred_dx,
  input  logic signed [MV_W-1:0]   pred_dy,
  output logic signed [MV_W-1:0]   best_dx,
  output logic signed [MV_W-1:0]   best_dy,
  output logic [SAD_W-1:0]         best_sad,
  output logic                     done
);
  import mesad_pkg::*;

  localparam int SPAN     = 2*RANGE + 1;
  localparam int OW       = $clog2(SPAN);
  localparam int CUR_BITS = BLK*BLK*PIX_W;
  localparam int WIN_BITS = WIN*WIN*PIX_W;

  function automatic logic [OW-1:0] clamp_org(input logic signed [MV_W-1:0] v);
    if (int'(v) < -RANGE)     return '0;
    else if (int'(v) > RANGE) return OW'(SPAN-1);
    else                      return OW'(int'(v) + RANGE);
  endfunction

  function automatic logic signed [MV_W-1:0] org_to_mv(input logic [OW-1:0] o);
    return MV_W'(int'(o) - RANGE);
  endfunction

  mesad_state_e         state;
  logic [CUR_BITS-1:0]  cur_buf;
  logic [WIN_BITS-1:0]  win_buf;
  logic [OW-1:0]        seed_oy, seed_ox;
  logic [OW-1:0]        scan_oy, scan_ox;
  logic [SAD_W-1:0]     min_sad;

  logic [OW-1:0]        par_oy, par_ox;
  logic [SAD_W-1:0]     part_sum;

  // named internal events
  logic                 busy_w;
  logic                 pass_w;
  logic                 stall_w;
  logic                 push_w;
  logic                 scan_last;
  logic [2*OW-1:0]      scan_pos_w;
  logic                 q_full;
  logic                 odd_idle;
  logic                 commit_w;
  logic [OW-1:0]        commit_oy, commit_ox;
  logic [SAD_W-1:0]     commit_sad;
  logic                 commit_seed;
  logic                 take_w;

  assign par_oy     = (state == ST_SEED) ? seed_oy : scan_oy;
  assign par_ox     = (state == ST_SEED) ? seed_ox : scan_ox;
  assign busy_w     = (state != ST_IDLE);
  assign pass_w     = (state == ST_SCAN) && (part_sum < min_sad);
  assign stall_w    = pass_w && q_full;
  assign push_w     = (state == ST_SEED) || (pass_w && !q_full);
  assign scan_last  = (scan_oy == OW'(SPAN-1)) && (scan_ox == OW'(SPAN-1));
  assign scan_pos_w = {scan_oy, scan_ox};
  assign take_w     = commit_w && (commit_seed || (commit_sad < min_sad));

  mesad_even_sum #(
    .PIX_W(PIX_W), .BLK(BLK), .WIN(WIN), .OW(OW), .SAD_W(SAD_W)
  ) u_even (
    .cur(cur_buf), .win(win_buf), .oy(par_oy), .ox(par_ox), .part(part_sum)
  );

  mesad_odd_unit #(
    .PIX_W(PIX_W), .BLK(BLK), .WIN(WIN), .OW(OW), .SAD_W(SAD_W)
  ) u_odd (
    .clk(clk), .rst_n(rst_n), .cur(cur_buf), .win(win_buf),
    .push(push_w), .push_oy(par_oy), .push_ox(par_ox),
    .push_part(part_sum), .push_seed(state == ST_SEED),
    .q_full(q_full), .idle(odd_idle),
    .commit(commit_w), .commit_oy(commit_oy), .commit_ox(commit_ox),
    .commit_sad(commit_sad), .commit_seed(commit_seed)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cur_buf  <= '0;
      win_buf  <= '0;
      seed_oy  <= '0;
      seed_ox  <= '0;
      scan_oy  <= '0;
      scan_ox  <= '0;
      min_sad  <= '1;
      best_dx  <= '0;
      best_dy  <= '0;
      best_sad <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          cur_buf <= cur_blk;
          win_buf <= search_win;
          seed_oy <= clamp_org(pred_dy);
          seed_ox <= clamp_org(pred_dx);
          min_sad <= '1;
          state   <= ST_SEED;
        end
        ST_SEED: state <= ST_SETTLE;
        ST_SETTLE: if (odd_idle) begin
          scan_oy <= '0;
          scan_ox <= '0;
          state   <= ST_SCAN;
        end
        ST_SCAN: if (!stall_w) begin
          if (scan_last) begin
            state <= ST_DRAIN;
          end else if (scan_ox == OW'(SPAN-1)) begin
            scan_ox <= '0;
            scan_oy <= scan_oy + OW'(1);
          end else begin
            scan_ox <= scan_ox + OW'(1);
          end
        end
        ST_DRAIN: if (odd_idle) begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase

      if (take_w) begin
        min_sad  <= commit_sad;
        best_sad <= commit_sad;
        best_dy  <= org_to_mv(commit_oy);
        best_dx  <= org_to_mv(commit_ox);
      end
    end
  end

endmodule

// File: rtl/mesad_chk.sv
module mesad_chk #(
  parameter int SAD_W    = 15,
  parameter int WIN_BITS = 2048,
  parameter int POS_W    = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic                busy,
  input logic                done,
  input logic                stall,
  input logic [POS_W-1:0]    scan_pos,
  input logic                odd_idle,
  input logic                commit,
  input logic                commit_seed,
  input logic [SAD_W-1:0]    commit_sad,
  input logic [SAD_W-1:0]    best_sad,
  input logic [WIN_BITS-1:0] win_buf
);

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> odd_idle);

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(scan_pos));

  // R8
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(win_buf));

  // R4
  no_worse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !commit_seed && (commit_sad >= best_sad)) |=> $stable(best_sad));

endmodule

bind me_search_top mesad_chk #(
  .SAD_W(SAD_W), .WIN_BITS(WIN_BITS), .POS_W(2*OW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy_w), .done(done),
  .stall(stall_w), .scan_pos(scan_pos_w), .odd_idle(odd_idle),
  .commit(commit_w), .commit_seed(commit_seed), .commit_sad(commit_sad),
  .best_sad(best_sad), .win_buf(win_buf)
);

// File: tb/me_search_top_test.sv
`timescale 1ns/1ps
module me_search_top_test;
  localparam int PW    = 8;
  localparam int BLK   = 8;
  localparam int RNG   = 4;
  localparam int MVW   = 8;
  localparam int WIN   = BLK + 2*RNG;
  localparam int SPAN  = 2*RNG + 1;
  localparam int NCAND = SPAN*SPAN;
  localparam int SADW  = PW + $clog2(BLK*BLK) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [BLK*BLK*PW-1:0] cur_blk = '0;
  logic [WIN*WIN*PW-1:0] search_win = '0;
  logic signed [MVW-1:0] pred_dx = '0, pred_dy = '0;
  logic signed [MVW-1:0] best_dx, best_dy;
  logic [SADW-1:0] best_sad;
  logic done;

  always #4 clk = ~clk;

  me_search_top #(.PIX_W(PW), .BLK(BLK), .RANGE(RNG), .MV_W(MVW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cur_blk(cur_blk),
    .search_win(search_win), .pred_dx(pred_dx), .pred_dy(pred_dy),
    .best_dx(best_dx), .best_dy(best_dy), .best_sad(best_sad), .done(done)
  );

  int checks = 0;
  int errors = 0;
  int cur_px [BLK*BLK];
  int win_px [WIN*WIN];
  bit searching = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // every clock: done may only appear while a search is outstanding (R7)
  always @(negedge clk) begin
    if (rst_n && !searching) check(done == 1'b0, "R7 stray done", int'(done), 0);
  end

  initial begin
    #(200000*8);
    check(1'b0, "watchdog", 0, 1);
    finish_up();
  end

  function automatic int ref_sad(int dy, int dx);
    int s = 0;
    for (int r = 0; r < BLK; r++)
      for (int c = 0; c < BLK; c++) begin
        int d = cur_px[r*BLK+c] - win_px[(r+dy+RNG)*WIN + c+dx+RNG];
        s += (d < 0) ? -d : d;
      end
    return s;
  endfunction

  function automatic int clampi(int v);
    return (v < -RNG) ? -RNG : (v > RNG) ? RNG : v;
  endfunction

  task automatic drive_pixels();
    for (int i = 0; i < BLK*BLK; i++) cur_blk[i*PW +: PW] = PW'(cur_px[i]);
    for (int i = 0; i < WIN*WIN; i++) search_win[i*PW +: PW] = PW'(win_px[i]);
  endtask

  // run one search; bound>0 limits cycles from start to done; disturb pulses start mid-search
  task automatic run_case(input string tag, input int pdy, input int pdx,
                          input int bound, input bit disturb);
    int ey, ex, es, m, cyc;
    bit got;
    m = 1 << 30;
    for (int dy = -RNG; dy <= RNG; dy++)
      for (int dx = -RNG; dx <= RNG; dx++)
        if (ref_sad(dy, dx) < m) begin m = ref_sad(dy, dx); ey = dy; ex = dx; end
    if (ref_sad(clampi(pdy), clampi(pdx)) == m) begin ey = clampi(pdy); ex = clampi(pdx); end
    es = m;

    drive_pixels();
    pred_dy = MVW'(pdy);
    pred_dx = MVW'(pdx);
    @(negedge clk);
    searching = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    got = 1'b0;
    while (!got && cyc < 5000) begin
      if (disturb && cyc == 10) begin
        search_win = '0;
        cur_blk = '1;
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
      if (done) got = 1'b1;
      else begin @(negedge clk); cyc++; end
    end
    start = 1'b0;
    check(got, {tag, " R7 done seen"}, int'(got), 1);
    if (bound > 0) check(cyc <= bound, {tag, " R5 cycles"}, cyc, bound);
    check(int'(best_dy) == ey, {tag, " R2 R4 best_dy"}, int'(best_dy), ey);
    check(int'(best_dx) == ex, {tag, " R2 R4 best_dx"}, int'(best_dx), ex);
    check(int'(best_sad) == es, {tag, " R2 R9 best_sad"}, int'(best_sad), es);
    @(negedge clk);
    searching = 1'b0;
    check(done == 1'b0, {tag, " R7 one-cycle done"}, int'(done), 0);
    repeat (3) @(negedge clk);
    check(int'(best_sad) == es && int'(best_dx) == ex, {tag, " R7 hold"}, int'(best_sad), es);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(done == 1'b0, "R1 done", int'(done), 0);
    check(best_sad == '0, "R1 best_sad", int'(best_sad), 0);
    check(best_dx == '0 && best_dy == '0, "R1 vector", int'(best_dx), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2: exact match embedded at dy=2, dx=-3
    for (int i = 0; i < WIN*WIN; i++) win_px[i] = int'($urandom_range(0, 255));
    for (int r = 0; r < BLK; r++)
      for (int c = 0; c < BLK; c++) cur_px[r*BLK+c] = win_px[(r+6)*WIN + c+1];
    run_case("embed", 0, 0, 0, 1'b0);

    // R5: prediction lands on the exact match, so no survivor reaches the odd rows
    for (int r = 0; r < BLK; r++)
      for (int c = 0; c < BLK; c++) cur_px[r*BLK+c] = win_px[(r+3)*WIN + c+5];
    run_case("predhit", -1, 1, NCAND + 16, 1'b0);

    // R3 R4: flat data, every SAD equal, clamped prediction wins
    for (int i = 0; i < WIN*WIN; i++) win_px[i] = 10;
    for (int i = 0; i < BLK*BLK; i++) cur_px[i] = 12;
    run_case("flatclamp", 10, -9, 0, 1'b0);
    check(int'(best_dy) == RNG && int'(best_dx) == -RNG, "R3 clamp vector", int'(best_dy), RNG);

    // R4: whole row of equal minima, first in raster order wins
    for (int y = 0; y < WIN; y++)
      for (int x = 0; x < WIN; x++) win_px[y*WIN+x] = y*13;
    for (int r = 0; r < BLK; r++)
      for (int c = 0; c < BLK; c++) cur_px[r*BLK+c] = (r+1)*13;
    run_case("tierow", 4, 0, 0, 1'b0);
    check(int'(best_dy) == -3 && int'(best_dx) == -4, "R4 earliest tie", int'(best_dx), -4);

    // R9: largest SAD value
    for (int i = 0; i < WIN*WIN; i++) win_px[i] = 0;
    for (int i = 0; i < BLK*BLK; i++) cur_px[i] = 255;
    run_case("maxsad", -2, 3, 0, 1'b0);

    // R6: random data with varied predictions, survivors contend for the slot
    for (int t = 0; t < 6; t++) begin
      for (int i = 0; i < WIN*WIN; i++) win_px[i] = int'($urandom_range(0, 255));
      for (int i = 0; i < BLK*BLK; i++) cur_px[i] = int'($urandom_range(0, 255));
      run_case("random R6", int'($urandom_range(0, 8)) - 4, int'($urandom_range(0, 8)) - 4, 0, 1'b0);
    end

    // R6: smooth gradient, many partials fall under the threshold
    for (int y = 0; y < WIN; y++)
      for (int x = 0; x < WIN; x++) win_px[y*WIN+x] = (x*7 + y*5) % 256;
    for (int r = 0; r < BLK; r++)
      for (int c = 0; c < BLK; c++) cur_px[r*BLK+c] = (c*7 + r*5 + 30) % 256;
    run_case("gradient R6", 4, 4, 0, 1'b0);

    // R8: start pulse with new inputs during a search is ignored
    for (int i = 0; i < WIN*WIN; i++) win_px[i] = int'($urandom_range(0, 255));
    for (int r = 0; r < BLK; r++)
      for (int c = 0; c < BLK; c++) cur_px[r*BLK+c] = win_px[(r+1)*WIN + c+7];
    run_case("busystart R8", 0, 0, 0, 1'b1);

    finish_up();
  end

endmodule